// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer

This block is a single PWM timer channel. One up-counter is shared by two waveform outputs, A and B. A prescaler slows the counter by a power of four. The counter climbs from zero to a programmed period value and then restarts at zero. Each output has its own compare value. Each output also has a small pin-control code that states three things: the level the output starts at, what happens to the output when the cycle ends, and what happens when the counter reaches that output's compare value.

Software controls the channel through a word-wide register port. It starts the counter, chooses the prescaler, loads the period and the two compare values, and writes both pin-control codes together with their enable bits. The counter value can be read back at any time. The timing fields can only be changed while the counter is stopped. The usual setup programs both outputs for normal-polarity PWM, where the high time equals the compare value.

Top module: `pwm_saw_timer`

## Requirements
- R1: After reset every register reads 0, the counter is 0, the counter is stopped, and both outputs are low.
- R2: The counter advances only when all three of these hold: the run bit (control bit 0) is 1, the direction bit reads 1, and the mode field (control bits 18:16) is 0. Otherwise the counter holds its value.
- R3: The prescaler select N is in control bits 26:24. The counter steps once every 4^N clocks. Any select value above 5 acts as 5, which divides by 1024.
- R4: A control write made while the run bit is 1 leaves the mode and prescaler fields unchanged on readback. The run bit itself takes every write.
- R5: The counter counts 0, 1, …, P and then wraps to 0, where P is the period register. A PWM cycle is therefore P+1 counter steps. The count reads at address 6.
- R6: The pin-control register holds the code for output A in bits 4:0 and the code for output B in bits 20:16. Within a code:
  - bit 4 is the initial level;
  - bits 3:2 are the action at cycle end (the wrap);
  - bits 1:0 are the action at compare match (the counter stepping onto the compare value);
  - the action encoding is 00 keep, 01 low, 10 high, 11 toggle;
  - when both events fall on the same step, the end action is applied first and the match action second.
- R7: Code 0x1B with compare value C gives a waveform that is high for C steps out of every P+1 steps.
- R8: With code 0x1B, a compare value greater than P never matches, so the output stays high (100%). A compare value of 0 keeps the output low (0%).
- R9: The output-enable bits are pin-control bit 8 for A and bit 24 for B. While an enable bit is 0, its output is low.
- R10: While the counter is not advancing, each output's internal level is held at the initial-level bit of its code.
- R11: Direction register (address 1):
  - a write changes the direction bit to wdata bit 0 only if wdata bit 1 is set in the same write;
  - bit 1 always reads as 0.
- R12: Register map:
  - address 0 is control;
  - address 1 is direction;
  - address 2 is pin-control, which reads back with mask 0x011F011F;
  - address 3 is the period;
  - address 4 is compare A;
  - address 5 is compare B;
  - address 6 is the count;
  - the timing registers keep the low CNT_W bits of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_a | output | 1 | Waveform output A |
| pwm_b | output | 1 | Waveform output B |

## Verification
The bench goes after these corner cases:
- **Coincident events.** A compare value of zero makes the match and the wrap fall on the same step. If the ordering were wrong, a 0% setting would show a one-step spike or stay high.
- **Compare above the period.** If the comparator matched in the wrong place, a 100% setting would dip low once per cycle.
- **Clamped prescaler select.** A design that did not clamp the select would count far too fast, or never count at all.
- **Writes while running.** A design that let timing fields change while running would report a new mode or prescaler on readback and change the step rate in mid-run.
- **Unforced direction writes.** A direction write without bit 1 set must not start the counter.
- **Stop and restart.** The outputs must fall back to their initial level while stopped, or the first cycle after a restart comes out inverted.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;
   localparam int REG_W = 32;

   // register addresses
   localparam int A_CTRL   = 0;
   localparam int A_DIR    = 1;
   localparam int A_PIN    = 2;
   localparam int A_PERIOD = 3;
   localparam int A_CMPA   = 4;
   localparam int A_CMPB   = 5;
   localparam int A_COUNT  = 6;

   // control field positions
   localparam int RUN_BIT  = 0;
   localparam int MODE_LSB = 16;
   localparam int PSC_LSB  = 24;
   localparam int FLD_W    = 3;
   localparam logic [FLD_W-1:0] MODE_SAW = 3'd0;

   // pin-control layout: per output, stride 16
   localparam int PIN_STRIDE = 16;
   localparam int CODE_W     = 5;
   localparam int OE_OFS     = 8;
   localparam logic [REG_W-1:0] PIN_MASK = 32'h011F_011F;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } pin_act_e;

   typedef struct packed {
      logic     init_lvl;
      pin_act_e end_act;
      pin_act_e match_act;
   } pin_code_t;

   function automatic logic apply_act(pin_act_e a, logic lvl);
      case (a)
         ACT_KEEP: return lvl;
         ACT_LOW:  return 1'b0;
         ACT_HIGH: return 1'b1;
         default:  return ~lvl;
      endcase
   endfunction
endpackage

// File: rtl/pwm_saw_prescaler.sv
module pwm_saw_prescaler #(
   parameter int SEL_MAX = 5,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = 2 * SEL_MAX;

   if (SEL_MAX < 1 || SEL_MAX >= (1 << SEL_W)) begin : g_bad_sel
      $error("pwm_saw_prescaler: SEL_MAX must be in 1..2**SEL_W-1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim_m1;
   logic [SEL_W-1:0] sel_c;

   always_comb begin
      sel_c  = (sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel;
      lim_m1 = '0;
      for (int i = 0; i < SEL_MAX; i++) begin
         if (SEL_W'(i) < sel_c) lim_m1[2*i +: 2] = 2'b11;
      end
   end

   assign tick = en && (pre_q == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pre_q <= '0;
      else if (!en || tick)  pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
   end

   // with a divider of at least 4, two ticks never fall on adjacent clocks
   p_tick_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel_c != '0) |=> !tick);
endmodule

// File: rtl/pwm_saw_counter.sv
module pwm_saw_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt,
   output logic             wrap
);
   assign wrap = tick && (cnt == period);
   assign nxt  = wrap ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= nxt;
   end

   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));
   p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_saw_out.sv
module pwm_saw_out
   import pwm_saw_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             wrap,
   input  logic [CNT_W-1:0] nxt,
   input  logic [CNT_W-1:0] cmp,
   input  pin_code_t        code,
   input  logic             oe,
   output logic             pin
);
   logic lvl_q;
   logic lvl_end;
   logic lvl_new;

   always_comb begin
      lvl_end = wrap ? apply_act(code.end_act, lvl_q) : lvl_q;
      lvl_new = (tick && nxt == cmp) ? apply_act(code.match_act, lvl_end) : lvl_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= 1'b0;
      else if (!active) lvl_q <= code.init_lvl;
      else              lvl_q <= lvl_new;
   end

   assign pin = oe & lvl_q;

   p_idle_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (lvl_q == $past(code.init_lvl)));
endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
   import pwm_saw_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SEL_MAX = 5,
   parameter int ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              pwm_a,
   output logic              pwm_b
);
   localparam int N_OUT = 2;

   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
      $error("pwm_saw_timer: CNT_W must be in 2..32");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pwm_saw_timer: ADDR_W must be at least 3");
   end

   logic             run_q;
   logic [FLD_W-1:0] mode_q;
   logic [FLD_W-1:0] psc_q;
   logic             dir_q;
   logic [REG_W-1:0] pin_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] cmp_q [N_OUT];

   logic             active;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] nxt;
   logic [N_OUT-1:0] pins;

   assign active = run_q && dir_q && (mode_q == MODE_SAW);

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         mode_q   <= '0;
         psc_q    <= '0;
         dir_q    <= 1'b0;
         pin_q    <= '0;
         period_q <= '0;
         for (int k = 0; k < N_OUT; k++) cmp_q[k] <= '0;
      end else if (reg_wr) begin
         case (int'(reg_addr))
            A_CTRL: begin
               run_q <= reg_wdata[RUN_BIT];
               if (!run_q) begin
                  mode_q <= reg_wdata[MODE_LSB +: FLD_W];
                  psc_q  <= reg_wdata[PSC_LSB +: FLD_W];
               end
            end
            A_DIR:    if (reg_wdata[1]) dir_q <= reg_wdata[0];
            A_PIN:    pin_q    <= reg_wdata;
            A_PERIOD: period_q <= reg_wdata[CNT_W-1:0];
            A_CMPA:   cmp_q[0] <= reg_wdata[CNT_W-1:0];
            A_CMPB:   cmp_q[1] <= reg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // register reads
   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         A_CTRL: begin
            reg_rdata[RUN_BIT]            = run_q;
            reg_rdata[MODE_LSB +: FLD_W]  = mode_q;
            reg_rdata[PSC_LSB +: FLD_W]   = psc_q;
         end
         A_DIR:    reg_rdata[0] = dir_q;
         A_PIN:    reg_rdata    = pin_q & PIN_MASK;
         A_PERIOD: reg_rdata    = REG_W'(period_q);
         A_CMPA:   reg_rdata    = REG_W'(cmp_q[0]);
         A_CMPB:   reg_rdata    = REG_W'(cmp_q[1]);
         A_COUNT:  reg_rdata    = REG_W'(cnt);
         default:  reg_rdata    = '0;
      endcase
   end

   pwm_saw_prescaler #(.SEL_MAX(SEL_MAX), .SEL_W(FLD_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .en(active), .sel(psc_q), .tick(tick)
   );

   pwm_saw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_q),
      .cnt(cnt), .nxt(nxt), .wrap(wrap)
   );

   for (genvar g = 0; g < N_OUT; g++) begin : g_out
      pwm_saw_out #(.CNT_W(CNT_W)) u_out (
         .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .wrap(wrap),
         .nxt(nxt), .cmp(cmp_q[g]),
         .code(pin_code_t'(pin_q[PIN_STRIDE*g +: CODE_W])),
         .oe(pin_q[PIN_STRIDE*g + OE_OFS]),
         .pin(pins[g])
      );
   end

   assign pwm_a = pins[0];
   assign pwm_b = pins[1];

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(cnt));
   p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && reg_wr && int'(reg_addr) == A_CTRL) |=> ($stable(mode_q) && $stable(psc_q)));
   p_oe_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_q[OE_OFS]) |-> !pwm_a);
endmodule

// File: tb/sim_pwm_saw_timer.sv
module sim_pwm_saw_timer;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr = 0;
   logic [2:0]  addr = 3'd6;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic        pwm_a, pwm_b;

   int checks = 0, fails = 0, cyc = 0;
   bit mon_on = 0;

   always #2.5 clk = ~clk;

   pwm_saw_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   // behavioural reference model
   int m_run, m_mode, m_psc, m_dir, m_pin, m_per, m_ca, m_cb;
   int m_pre, m_cnt, m_la, m_lb, m_lim, m_nxt, m_wrap;
   localparam int MASK = 32'h0000_FFFF;

   function automatic int act(int a, int l);
      case (a & 3)
         0: return l;
         1: return 0;
         2: return 1;
         default: return l ^ 1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_mode = 0; m_psc = 0; m_dir = 0; m_pin = 0;
         m_per = 0; m_ca = 0; m_cb = 0; m_pre = 0; m_cnt = 0; m_la = 0; m_lb = 0;
      end else begin
         if (m_run != 0 && m_dir != 0 && m_mode == 0) begin
            m_lim = 1 << (2 * ((m_psc > 5) ? 5 : m_psc));
            if (m_pre == m_lim - 1) begin
               m_pre  = 0;
               m_wrap = (m_cnt == m_per) ? 1 : 0;
               m_nxt  = m_wrap ? 0 : ((m_cnt + 1) & MASK);
               if (m_wrap) begin
                  m_la = act((m_pin >> 2), m_la);
                  m_lb = act((m_pin >> 18), m_lb);
               end
               if (m_nxt == m_ca) m_la = act(m_pin, m_la);
               if (m_nxt == m_cb) m_lb = act((m_pin >> 16), m_lb);
               m_cnt = m_nxt;
            end else m_pre++;
         end else begin
            m_pre = 0;
            m_la = (m_pin >> 4) & 1;
            m_lb = (m_pin >> 20) & 1;
         end
         if (wr) begin
            case (addr)
               3'd0: begin
                  if (m_run == 0) begin
                     m_mode = (wdata >> 16) & 7;
                     m_psc  = (wdata >> 24) & 7;
                  end
                  m_run = wdata[0];
               end
               3'd1: if (wdata[1]) m_dir = wdata[0];
               3'd2: m_pin = wdata;
               3'd3: m_per = wdata & MASK;
               3'd4: m_ca  = wdata & MASK;
               3'd5: m_cb  = wdata & MASK;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string req, logic [31:0] actv, logic [31:0] expv);
      checks++;
      if (actv !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, actv, expv);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         chk("R6 pwm_a", {31'b0, pwm_a}, 32'((m_la & ((m_pin >> 8) & 1))));
         chk("R6 pwm_b", {31'b0, pwm_b}, 32'((m_lb & ((m_pin >> 24) & 1))));
         if (addr == 3'd6) chk("R5 count", rdata, 32'(m_cnt));
      end
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   task automatic wreg(logic [2:0] a, logic [31:0] d);
      @(posedge clk); #1;
      wr = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr = 0; addr = 3'd6; wdata = 0;
   endtask

   task automatic rreg(string req, logic [2:0] a, logic [31:0] expv);
      @(posedge clk); #1;
      addr = a; #1;
      chk(req, rdata, expv);
      addr = 3'd6;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic duty(string req, int cycles, int expv);
      int highs = 0;
      do @(negedge clk); while (rdata != 0);
      for (int i = 0; i < cycles; i++) begin
         if (pwm_a) highs++;
         @(negedge clk);
      end
      chk(req, 32'(highs), 32'(expv));
   endtask

   initial begin
      idle(3);
      #1 rst_n = 1;
      // R1: reset state
      rreg("R1 ctrl", 3'd0, 0);
      rreg("R1 dir", 3'd1, 0);
      rreg("R1 pin", 3'd2, 0);
      rreg("R1 period", 3'd3, 0);
      rreg("R1 count", 3'd6, 0);
      chk("R1 pins", {30'b0, pwm_a, pwm_b}, 0);
      mon_on = 1;

      // R11: unforced direction write ignored, forced write applied
      wreg(3'd1, 32'h1);
      rreg("R11 unforced", 3'd1, 0);
      wreg(3'd1, 32'h3);
      rreg("R11 forced", 3'd1, 1);

      // R12 / R7: normal PWM on both outputs
      wreg(3'd2, 32'hFFFF_FFFF);
      rreg("R12 pin mask", 3'd2, 32'h011F_011F);
      wreg(3'd2, 32'h011B_011B);
      wreg(3'd3, 32'h0001_0009);
      rreg("R12 period truncated", 3'd3, 9);
      wreg(3'd4, 3);
      wreg(3'd5, 7);
      wreg(3'd0, 32'h1);
      idle(25);
      duty("R7 duty A=3 of 10", 10, 3);

      // R4: mode/prescaler write while running ignored
      wreg(3'd0, 32'h0201_0001);
      rreg("R4 ctrl locked", 3'd0, 32'h1);
      idle(12);

      // R2 / R10: stop, count holds, levels return to initial
      wreg(3'd0, 32'h0);
      idle(6);
      chk("R10 idle level A", {31'b0, pwm_a}, 1);

      // R3: prescaler /4
      wreg(3'd0, 32'h0100_0001);
      rreg("R3 ctrl psc", 3'd0, 32'h0100_0001);
      idle(90);
      // R3: select 7 clamps to /1024
      wreg(3'd0, 32'h0);
      wreg(3'd3, 2);
      wreg(3'd0, 32'h0700_0001);
      idle(1030);
      rreg("R3 clamp one step", 3'd6, 1);
      idle(2100);
      wreg(3'd0, 32'h0);

      // R8: compare beyond period and compare zero
      wreg(3'd3, 9);
      wreg(3'd4, 12);
      wreg(3'd5, 0);
      wreg(3'd0, 32'h1);
      idle(15);
      duty("R8 100 percent", 10, 10);
      chk("R8 zero percent", {31'b0, pwm_b}, 0);
      idle(10);

      // R6: other codes (A: init low, end low, match high; B: toggle both)
      wreg(3'd0, 32'h0);
      wreg(3'd4, 4);
      wreg(3'd5, 5);
      wreg(3'd2, 32'h010F_0106);
      wreg(3'd0, 32'h1);
      idle(40);
      duty("R6 inverted A", 10, 6);

      // R9: output enable A cleared
      wreg(3'd2, 32'h010F_0006);
      idle(3);
      chk("R9 pwm_a disabled", {31'b0, pwm_a}, 0);
      idle(20);

      // R2: non-zero mode and cleared direction hold the counter
      wreg(3'd0, 32'h0);
      wreg(3'd0, 32'h0001_0001);
      idle(4);
      rreg("R2 mode hold", 3'd6, 32'(m_cnt));
      idle(10);
      wreg(3'd0, 32'h0);
      wreg(3'd0, 32'h1);
      wreg(3'd1, 32'h2);
      idle(10);
      rreg("R2 dir hold", 3'd6, 32'(m_cnt));

      idle(2);
      summary();
   end
endmodule